// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles control flow while an instruction is still in the decode stage of a five-stage in-order pipeline. It compares the two source operands of a conditional branch, works out the branch and jump destinations, and tells the fetch logic which address to use next. A taken branch or a jump then costs a single squashed fetch rather than a three-cycle wait for a later stage.

Results that are still in flight are routed into the comparator from the memory and write-back stages. When a needed value cannot be routed yet, the unit holds decode. That happens when the producer is still in execute, or when it is a load still reading memory. During a hold the surrounding pipeline keeps the PC and the decode register and sends a bubble into execute. The unit is purely combinational. It sits between the decode register and the fetch PC multiplexer.

Top module: `dbr_unit`

## Requirements
- R1: An instruction whose opcode (bits 31:26) is neither 6'b000100 (beq), 6'b000101 (bne) nor 6'b000010 (j) gives `npc_sel`=0 (sequential), `if_flush`=0 and `stall`=0.
- R2: Except for a jump, `tgt_addr` equals `id_pc4` plus the sign-extended offset in bits 15:0 shifted left by two. This holds whether or not the branch is taken. A taken branch gives `npc_sel`=1 and `if_flush`=1.
- R3: beq is taken exactly when the two compared operands are equal, and bne exactly when they differ. A branch that is not taken gives `npc_sel`=0 and `if_flush`=0. `cmp_eq` shows the equality of the compared operands.
- R4: A jump gives `npc_sel`=2, `if_flush`=1 and `stall`=0, even when later stages write registers named by its bits. Its `tgt_addr` is `id_pc4[31:28]` joined with bits 25:0 and two zero bits.
- R5: The first comparator operand (register number in bits 25:21) takes `mem_result` when the memory stage writes, is not a load, and has a nonzero `mem_dst` equal to that register.
- R6: The second comparator operand (register number in bits 20:16) takes `mem_result` under the same rule, matched against its own register number.
- R7: If the memory stage does not supply an operand, a write-back stage that writes a matching nonzero `wb_dst` supplies `wb_result`. This includes load data.
- R8: When the memory and write-back stages both match the same source, the memory-stage value wins.
- R9: Register 0 is never forwarded and never causes a stall. Its operand is the register-file value.
- R10: A branch whose source register is written by the instruction in execute (`ex_wen`, nonzero `ex_dst`) raises `stall`. While stalled, `npc_sel`=0 and `if_flush`=0, even if the other source is forwardable.
- R11: A branch whose source register is the nonzero destination of a load in the memory stage raises `stall`. A load there writing an unrelated register does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction held in the decode register |
| id_pc4 | input | 32 | Address of the decode instruction plus four |
| rf_a_data | input | 32 | Register-file read of the first source |
| rf_b_data | input | 32 | Register-file read of the second source |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_dst | input | 5 | Destination of the instruction in execute |
| mem_wen | input | 1 | Instruction in memory stage writes a register |
| mem_load | input | 1 | Instruction in memory stage is a load |
| mem_dst | input | 5 | Destination of the memory-stage instruction |
| mem_result | input | 32 | ALU result carried in the memory stage |
| wb_wen | input | 1 | Instruction in write-back writes a register |
| wb_dst | input | 5 | Destination of the write-back instruction |
| wb_result | input | 32 | Value being written back |
| npc_sel | output | 2 | Next-PC choice: 0 sequential, 1 branch, 2 jump |
| tgt_addr | output | 32 | Branch or jump destination |
| stall | output | 1 | Hold decode and insert an execute bubble |
| if_flush | output | 1 | Clear the fetched instruction to a no-op |
| cmp_eq | output | 1 | Compared operands are equal |

## Verification
Two functions can meet in one cycle: the hazard hold and operand forwarding. One branch source can be produced in execute while the other is ready to be routed from the memory stage. The bench sets up that case, and a taken-looking outcome must not win. The check expects `stall` high with neither redirect nor flush. The same meeting is tried with the memory-stage load case. A second overlap has both stages matching one source. The bench makes the two results differ so that the operand chosen shows up in whether the branch is taken.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NSRC   = 2;

    localparam logic [5:0] OPC_BEQ = 6'b000100;
    localparam logic [5:0] OPC_BNE = 6'b000101;
    localparam logic [5:0] OPC_JMP = 6'b000010;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic              is_br;
        logic              is_bne;
        logic              is_jmp;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
    } dec_info_t;

    function automatic logic [XLEN-1:0] calc_br_target(
        input logic [XLEN-1:0] pc4,
        input logic [15:0]     off
    );
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-16){off[15]}}, off};
        return pc4 + (ext << 2);
    endfunction

    function automatic logic [XLEN-1:0] calc_jmp_target(
        input logic [XLEN-1:0] pc4,
        input logic [25:0]     idx
    );
        return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc4,
    output dec_info_t       info,
    output logic [XLEN-1:0] br_tgt,
    output logic [XLEN-1:0] jmp_tgt
);
    logic [5:0] opc;

    always_comb begin
        opc         = instr[31:26];
        info.is_br  = (opc == OPC_BEQ) || (opc == OPC_BNE);
        info.is_bne = (opc == OPC_BNE);
        info.is_jmp = (opc == OPC_JMP);
        info.src_a  = instr[25:21];
        info.src_b  = instr[20:16];
        br_tgt      = calc_br_target(pc4, instr[15:0]);
        jmp_tgt     = calc_jmp_target(pc4, instr[25:0]);
    end
endmodule

// File: rtl/dbr_opsel.sv
module dbr_opsel
    import dbr_pkg::*;
#(
    parameter int PORTS = NSRC
) (
    input  logic [PORTS-1:0][REG_AW-1:0] src,
    input  logic [PORTS-1:0][XLEN-1:0]   rf_data,
    input  logic                         ex_wen,
    input  logic [REG_AW-1:0]            ex_dst,
    input  logic                         mem_wen,
    input  logic                         mem_load,
    input  logic [REG_AW-1:0]            mem_dst,
    input  logic [XLEN-1:0]              mem_result,
    input  logic                         wb_wen,
    input  logic [REG_AW-1:0]            wb_dst,
    input  logic [XLEN-1:0]              wb_result,
    output logic [PORTS-1:0][XLEN-1:0]   operand,
    output logic [PORTS-1:0]             not_ready
);
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic live, from_mem, from_wb, ex_pend, ld_pend;

        always_comb begin
            live     = (src[p] != '0);
            from_mem = live && mem_wen && !mem_load && (mem_dst == src[p]);
            from_wb  = live && wb_wen && (wb_dst == src[p]);
            ex_pend  = live && ex_wen && (ex_dst == src[p]);
            ld_pend  = live && mem_wen && mem_load && (mem_dst == src[p]);

            if (from_mem)     operand[p] = mem_result;
            else if (from_wb) operand[p] = wb_result;
            else              operand[p] = rf_data[p];

            not_ready[p] = ex_pend || ld_pend;
        end
    end
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
    import dbr_pkg::*;
(
    input  logic [31:0]       id_instr,
    input  logic [XLEN-1:0]   id_pc4,
    input  logic [XLEN-1:0]   rf_a_data,
    input  logic [XLEN-1:0]   rf_b_data,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_wen,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [XLEN-1:0]   mem_result,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [XLEN-1:0]   wb_result,
    output logic [1:0]        npc_sel,
    output logic [XLEN-1:0]   tgt_addr,
    output logic              stall,
    output logic              if_flush,
    output logic              cmp_eq
);
    dec_info_t                   info;
    logic [XLEN-1:0]             br_tgt, jmp_tgt;
    logic [NSRC-1:0][XLEN-1:0]   opnd;
    logic [NSRC-1:0]             wait_src;
    logic                        taken;
    npc_sel_e                    sel;

    dbr_decode u_dec (
        .instr   (id_instr),
        .pc4     (id_pc4),
        .info    (info),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    dbr_opsel #(.PORTS(NSRC)) u_opsel (
        .src        ({info.src_b, info.src_a}),
        .rf_data    ({rf_b_data, rf_a_data}),
        .ex_wen     (ex_wen),
        .ex_dst     (ex_dst),
        .mem_wen    (mem_wen),
        .mem_load   (mem_load),
        .mem_dst    (mem_dst),
        .mem_result (mem_result),
        .wb_wen     (wb_wen),
        .wb_dst     (wb_dst),
        .wb_result  (wb_result),
        .operand    (opnd),
        .not_ready  (wait_src)
    );

    always_comb begin
        cmp_eq = (opnd[0] == opnd[1]);
        stall  = info.is_br && (|wait_src);
        taken  = info.is_br && !stall && (info.is_bne ? !cmp_eq : cmp_eq);

        if (info.is_jmp)  sel = NPC_JUMP;
        else if (taken)   sel = NPC_BRANCH;
        else              sel = NPC_SEQ;

        npc_sel  = sel;
        if_flush = taken || info.is_jmp;
        tgt_addr = info.is_jmp ? jmp_tgt : br_tgt;
    end
endmodule

// File: rtl/dbr_unit_chk.sv
module dbr_unit_chk
    import dbr_pkg::*;
(
    input logic [31:0] id_instr,
    input logic [1:0]  npc_sel,
    input logic        stall,
    input logic        if_flush,
    input logic        cmp_eq
);
    logic [5:0] opc;
    logic       ctl_op;

    always_comb begin
        opc    = id_instr[31:26];
        ctl_op = (opc == OPC_BEQ) || (opc == OPC_BNE) || (opc == OPC_JMP);

        // R1
        if (!ctl_op) begin
            idle_quiet_chk: assert (npc_sel == 2'd0 && !if_flush && !stall);
        end
        // R10
        if (stall) begin
            stall_holds_chk: assert (npc_sel == 2'd0 && !if_flush);
        end
        // R11
        if (stall) begin
            stall_on_branch_chk: assert (opc == OPC_BEQ || opc == OPC_BNE);
        end
        // R4
        if (npc_sel == 2'd2) begin
            jump_flush_chk: assert (if_flush && !stall);
        end
        // R2
        if (if_flush) begin
            flush_redirect_chk: assert (npc_sel != 2'd0);
        end
        // R3
        if (npc_sel == 2'd1) begin
            taken_sense_chk: assert ((opc == OPC_BEQ) ? cmp_eq : !cmp_eq);
        end
    end
endmodule

bind dbr_unit dbr_unit_chk u_chk (
    .id_instr (id_instr),
    .npc_sel  (npc_sel),
    .stall    (stall),
    .if_flush (if_flush),
    .cmp_eq   (cmp_eq)
);

// File: tb/dbr_unit_test.sv
module dbr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] id_instr, id_pc4, rf_a_data, rf_b_data, mem_result, wb_result;
    logic        ex_wen, mem_wen, mem_load, wb_wen;
    logic [4:0]  ex_dst, mem_dst, wb_dst;
    logic [1:0]  npc_sel;
    logic [31:0] tgt_addr;
    logic        stall, if_flush, cmp_eq;

    int checks = 0;
    int failures = 0;

    localparam logic [5:0] BEQ = 6'b000100;
    localparam logic [5:0] BNE = 6'b000101;
    localparam logic [5:0] JMP = 6'b000010;
    localparam logic [31:0] PC4 = 32'h0040_1000;

    always #10 clk = ~clk;

    dbr_unit uut (
        .id_instr(id_instr), .id_pc4(id_pc4),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .ex_wen(ex_wen), .ex_dst(ex_dst),
        .mem_wen(mem_wen), .mem_load(mem_load), .mem_dst(mem_dst),
        .mem_result(mem_result),
        .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_result(wb_result),
        .npc_sel(npc_sel), .tgt_addr(tgt_addr), .stall(stall),
        .if_flush(if_flush), .cmp_eq(cmp_eq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet_stages();
        ex_wen = 0; ex_dst = 0;
        mem_wen = 0; mem_load = 0; mem_dst = 0; mem_result = 0;
        wb_wen = 0; wb_dst = 0; wb_result = 0;
    endtask

    task automatic put_br(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b,
                          input logic [15:0] off, input logic [31:0] va, input logic [31:0] vb);
        @(posedge clk);
        id_instr = {op, a, b, off};
        id_pc4 = PC4;
        rf_a_data = va;
        rf_b_data = vb;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_idle();
        quiet_stages();
        put_br(6'b000000, 5'd3, 5'd4, 16'h0010, 32'd1, 32'd1);
        settle();
        chk("R1 sel", {30'b0, npc_sel}, 32'd0);
        chk("R1 flush", {31'b0, if_flush}, 32'd0);
        chk("R1 stall", {31'b0, stall}, 32'd0);
    endtask

    task automatic t_beq_rf();
        quiet_stages();
        put_br(BEQ, 5'd3, 5'd4, 16'hFFFC, 32'd5, 32'd5);
        settle();
        chk("R2 sel taken", {30'b0, npc_sel}, 32'd1);
        chk("R2 flush taken", {31'b0, if_flush}, 32'd1);
        chk("R2 target back", tgt_addr, 32'h0040_0FF0);
        chk("R3 cmp_eq", {31'b0, cmp_eq}, 32'd1);
        put_br(BEQ, 5'd3, 5'd4, 16'h0010, 32'd5, 32'd6);
        settle();
        chk("R3 beq ne sel", {30'b0, npc_sel}, 32'd0);
        chk("R3 beq ne flush", {31'b0, if_flush}, 32'd0);
        chk("R2 target fwd untaken", tgt_addr, 32'h0040_1040);
    endtask

    task automatic t_bne();
        quiet_stages();
        put_br(BNE, 5'd7, 5'd8, 16'h0002, 32'd1, 32'd2);
        settle();
        chk("R3 bne taken", {30'b0, npc_sel}, 32'd1);
        chk("R3 bne cmp", {31'b0, cmp_eq}, 32'd0);
        put_br(BNE, 5'd7, 5'd8, 16'h0002, 32'd9, 32'd9);
        settle();
        chk("R3 bne equal not taken", {30'b0, npc_sel}, 32'd0);
        chk("R3 bne equal flush", {31'b0, if_flush}, 32'd0);
    endtask

    task automatic t_fwd_mem();
        quiet_stages();
        mem_wen = 1; mem_dst = 5'd3; mem_result = 32'd9;
        put_br(BEQ, 5'd3, 5'd4, 16'h0001, 32'd1, 32'd9);
        settle();
        chk("R5 mem to A", {30'b0, npc_sel}, 32'd1);
        mem_dst = 5'd4; mem_result = 32'd1;
        settle();
        chk("R6 mem to B", {30'b0, npc_sel}, 32'd1);
        chk("R6 stall", {31'b0, stall}, 32'd0);
    endtask

    task automatic t_fwd_wb();
        quiet_stages();
        wb_wen = 1; wb_dst = 5'd3; wb_result = 32'd9;
        put_br(BEQ, 5'd3, 5'd4, 16'h0001, 32'd1, 32'd9);
        settle();
        chk("R7 wb to A", {30'b0, npc_sel}, 32'd1);
        mem_wen = 1; mem_dst = 5'd3; mem_result = 32'd2;
        wb_result = 32'd9;
        settle();
        chk("R8 mem wins", {30'b0, npc_sel}, 32'd0);
        mem_result = 32'd9; wb_result = 32'd1;
        settle();
        chk("R8 mem wins taken", {30'b0, npc_sel}, 32'd1);
        quiet_stages();
        mem_wen = 1; mem_load = 1; mem_dst = 5'd12;
        wb_wen = 1; wb_load_dummy();
    endtask

    task automatic wb_load_dummy();
        wb_dst = 5'd4; wb_result = 32'd1;
        settle();
        chk("R7 wb load data to B", {30'b0, npc_sel}, 32'd1);
        chk("R11 unrelated load", {31'b0, stall}, 32'd0);
    endtask

    task automatic t_zero();
        quiet_stages();
        ex_wen = 1; ex_dst = 5'd0;
        mem_wen = 1; mem_dst = 5'd0; mem_result = 32'd7;
        wb_wen = 1; wb_dst = 5'd0; wb_result = 32'd8;
        put_br(BEQ, 5'd0, 5'd0, 16'h0004, 32'd0, 32'd0);
        settle();
        chk("R9 no stall", {31'b0, stall}, 32'd0);
        chk("R9 taken from rf", {30'b0, npc_sel}, 32'd1);
        rf_b_data = 32'd7;
        settle();
        chk("R9 no forward", {31'b0, cmp_eq}, 32'd0);
    endtask

    task automatic t_stall_ex();
        quiet_stages();
        ex_wen = 1; ex_dst = 5'd3;
        put_br(BEQ, 5'd3, 5'd4, 16'h0004, 32'd5, 32'd5);
        settle();
        chk("R10 stall", {31'b0, stall}, 32'd1);
        chk("R10 no flush", {31'b0, if_flush}, 32'd0);
        chk("R10 seq", {30'b0, npc_sel}, 32'd0);
        ex_dst = 5'd4; mem_wen = 1; mem_dst = 5'd3; mem_result = 32'd5;
        settle();
        chk("R10 stall beats forward", {31'b0, stall}, 32'd1);
        chk("R10 stall beats forward sel", {30'b0, npc_sel}, 32'd0);
    endtask

    task automatic t_stall_load();
        quiet_stages();
        mem_wen = 1; mem_load = 1; mem_dst = 5'd4; mem_result = 32'd5;
        put_br(BNE, 5'd3, 5'd4, 16'h0004, 32'd5, 32'd6);
        settle();
        chk("R11 load stall", {31'b0, stall}, 32'd1);
        chk("R11 load no flush", {31'b0, if_flush}, 32'd0);
        mem_dst = 5'd9;
        settle();
        chk("R11 other load", {31'b0, stall}, 32'd0);
        chk("R11 other load taken", {30'b0, npc_sel}, 32'd1);
    endtask

    task automatic t_jump();
        quiet_stages();
        ex_wen = 1; ex_dst = 5'd4;
        mem_wen = 1; mem_load = 1; mem_dst = 5'd4;
        @(posedge clk);
        id_instr = {JMP, 26'h0123456};
        id_pc4 = 32'hA000_0010;
        settle();
        chk("R4 sel", {30'b0, npc_sel}, 32'd2);
        chk("R4 flush", {31'b0, if_flush}, 32'd1);
        chk("R4 no stall", {31'b0, stall}, 32'd0);
        chk("R4 target", tgt_addr, 32'hA048_D158);
    endtask

    initial begin
        id_instr = 0; id_pc4 = 0; rf_a_data = 0; rf_b_data = 0;
        quiet_stages();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        settle();
        chk("R1 reset sel", {30'b0, npc_sel}, 32'd0);
        chk("R1 reset stall", {31'b0, stall}, 32'd0);
        t_idle();
        t_beq_rf();
        t_bne();
        t_fwd_mem();
        t_fwd_wb();
        t_zero();
        t_stall_ex();
        t_stall_load();
        t_jump();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule